// File: doc/BRIEF.md
# BCD Calendar Register File

This block keeps the time of day and the calendar date in binary counters and presents them to software as eight byte-wide registers holding packed BCD. The counters are advanced by a one-cycle enable pulse that arrives once per second. The rollover logic knows the length of each month and takes February as 29 days in every year whose two-digit value is divisible by four. Software sets the time by writing BCD bytes. Each field is range-checked, and a byte that is out of range or is not valid BCD is dropped without any effect on that field.

A stop flag in the top bit of the seconds register freezes time. The block follows it with a two-state run controller. `ST_RUN` is the reset state, and in it every second pulse advances the counters. The `STOP` transition moves from `ST_RUN` to `ST_HALT` on any seconds write that has bit 7 set. In `ST_HALT` second pulses are ignored. The `RESUME` transition moves from `ST_HALT` back to `ST_RUN` on any seconds write that has bit 7 clear, and counting then continues from the held time.

The year register holds a two-digit value counted from a base year parameter. A spare flag is kept beside the weekday, and a control byte has some bits forced. The registers sit in the eight highest addresses of the byte map. The binary time is also driven straight onto output ports.

Top module: `bcd_clock_regs`

## Requirements
- R1: After reset the control register reads 0x90, seconds, minutes and hours read 0x00, weekday reads 0x00, date reads 0x01, month reads 0x01, year reads 0x00, the clock is running and `cur_year` equals BASE_YEAR.
- R2: A write to the seconds register (offset 1) takes BCD from bits 6:0 and stores it only if both digits are 0 to 9 and the value is 0 to 59. A read returns the stop flag in bit 7 and the BCD seconds in bits 6:0.
- R3: Bit 7 of every seconds write sets or clears the stop flag, whether or not the seconds value is accepted. While the flag is set, second pulses change nothing. After it is cleared, counting resumes from the held time.
- R4: Minutes (offset 2) take BCD from bits 6:0 and accept 0 to 59. Hours (offset 3) take BCD from bits 5:0 and accept 0 to 23. All other bits of these writes are ignored.
- R5: Date (offset 5) takes BCD from bits 5:0 and accepts 1 to 31. Month (offset 6) takes BCD from bits 4:0, accepts 1 to 12 and reads back as BCD 1 to 12.
- R6: Year (offset 7) accepts the whole byte as BCD 0 to 99 and reads back the same two digits. `cur_year` equals BASE_YEAR plus that value.
- R7: A weekday write (offset 4) stores bits 2:0 and, separately, bit 6. A read returns bit 6 in bit 6 and the weekday in bits 2:0, with all other bits zero.
- R8: A control write (offset 0) stores the written byte with bits 7 and 5 cleared and bits 7 and 4 then set, so it reads back as (v AND 0x5F) OR 0x90.
- R9: Each second pulse in `ST_RUN` adds one second. Seconds carry into minutes at 59, minutes carry into hours at 59, and hours carry into the date and the weekday at 23.
- R10: The date wraps to 1 after the last day of its month, with February having 29 days when the year value is divisible by 4 and 28 days otherwise. December wraps to January and increments the year, and year 99 wraps to 00. The weekday wraps from 6, or from 7, to 0.
- R11: The registers sit at byte addresses 2^ADDR_W-8 plus the offset. A read of any lower address returns 0xFF, and a write to one changes nothing.
- R12: `rdata` is loaded on the clock edge that samples `rd_en` and holds its value in every cycle without `rd_en`.
- R13: A second pulse in the same cycle as a write to a mapped register is dropped. A write to an unmapped address does not drop the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read byte, registered |
| tick_1hz | input | 1 | One-cycle pulse per second |
| cur_sec | output | 6 | Binary seconds |
| cur_min | output | 6 | Binary minutes |
| cur_hour | output | 5 | Binary hours |
| cur_wday | output | 3 | Weekday |
| cur_date | output | 5 | Binary date, 1 to 31 |
| cur_month | output | 4 | Binary month, 1 to 12 |
| cur_year | output | 16 | Full year |
| halted | output | 1 | High in ST_HALT |

## Verification
Every writable register is driven with all 256 byte values. The bench tracks the field it expects and compares each read-back. This separates the digit check from the range check, and it catches both ignored bit positions and forced bits. The timekeeping is first run through 3661 consecutive pulses, which exposes errors in the seconds, minutes and hours carries. Separate single-pulse tests cover the month ends: February in a leap year and in a common year, 30-day and 31-day months, and the end of the century. Further tests hit the stop path through an invalid seconds write, a pulse that coincides with a mapped write and with an unmapped write, and a write to an unmapped address whose low bits alias the seconds register.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [2:0] wday;
        logic [4:0] date;
        logic [3:0] mon0;   // zero-based month
        logic [6:0] yr;     // years past base
    } cal_t;

    typedef enum logic [2:0] {
        OFS_CTRL = 3'd0,
        OFS_SEC  = 3'd1,
        OFS_MIN  = 3'd2,
        OFS_HOUR = 3'd3,
        OFS_WDAY = 3'd4,
        OFS_DATE = 3'd5,
        OFS_MON  = 3'd6,
        OFS_YEAR = 3'd7
    } reg_ofs_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_st_e;

    typedef struct packed {
        logic ctrl;
        logic stop;
        logic sec;
        logic min;
        logic hour;
        logic wday;
        logic date;
        logic mon;
        logic yr;
    } wr_hit_t;

    function automatic logic bcd_digits_ok(input logic [7:0] v);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return 7'(({3'b0, v[7:4]} * 7'd10) + {3'b0, v[3:0]});
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [6:0] b);
        return {4'(b / 7'd10), 4'(b % 7'd10)};
    endfunction

    function automatic logic [4:0] month_days(input logic [3:0] mon0, input logic [6:0] yr);
        logic [4:0] d;
        unique case (mon0)
            4'd1:                     d = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd3, 4'd5, 4'd8, 4'd10:  d = 5'd30;
            default:                  d = 5'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bcdcal_wrdecode.sv
module bcdcal_wrdecode
    import bcdcal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output wr_hit_t           hit,
    output logic [6:0]        wbin,
    output logic              map_wr
);
    localparam int BASE = (1 << ADDR_W) - 8;

    reg_ofs_e   ofs;
    logic [7:0] fld;
    logic [6:0] lo;
    logic [6:0] hi;
    logic       in_rng;
    logic       mapped;

    assign mapped = (addr >= ADDR_W'(BASE));
    assign ofs    = reg_ofs_e'(addr[2:0]);
    assign map_wr = wr_en && mapped;

    always_comb begin
        fld = 8'h00;
        lo  = 7'd0;
        hi  = 7'd0;
        unique case (ofs)
            OFS_SEC, OFS_MIN: begin
                fld = {1'b0, wdata[6:0]};
                hi  = 7'd59;
            end
            OFS_HOUR: begin
                fld = {2'b0, wdata[5:0]};
                hi  = 7'd23;
            end
            OFS_DATE: begin
                fld = {2'b0, wdata[5:0]};
                lo  = 7'd1;
                hi  = 7'd31;
            end
            OFS_MON: begin
                fld = {3'b0, wdata[4:0]};
                lo  = 7'd1;
                hi  = 7'd12;
            end
            OFS_YEAR: begin
                fld = wdata;
                hi  = 7'd99;
            end
            default: begin
                fld = 8'h00;
            end
        endcase
    end

    assign wbin   = bcd_to_bin(fld);
    assign in_rng = bcd_digits_ok(fld) && (wbin >= lo) && (wbin <= hi);

    always_comb begin
        hit      = '0;
        hit.ctrl = map_wr && (ofs == OFS_CTRL);
        hit.stop = map_wr && (ofs == OFS_SEC);
        hit.wday = map_wr && (ofs == OFS_WDAY);
        hit.sec  = map_wr && in_rng && (ofs == OFS_SEC);
        hit.min  = map_wr && in_rng && (ofs == OFS_MIN);
        hit.hour = map_wr && in_rng && (ofs == OFS_HOUR);
        hit.date = map_wr && in_rng && (ofs == OFS_DATE);
        hit.mon  = map_wr && in_rng && (ofs == OFS_MON);
        hit.yr   = map_wr && in_rng && (ofs == OFS_YEAR);
    end

endmodule

// File: rtl/bcdcal_core.sv
module bcdcal_core
    import bcdcal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  wr_hit_t    hit,
    input  logic [6:0] wbin,
    input  logic [7:0] wdata,
    input  logic       map_wr,
    output cal_t       cal,
    output logic       halted,
    output logic [7:0] ctrl_q,
    output logic       wflag
);
    run_st_e state, state_nx;
    logic    adv_en;
    cal_t    adv;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (hit.stop && wdata[7])  state_nx = ST_HALT;  // STOP
            ST_HALT: if (hit.stop && !wdata[7]) state_nx = ST_RUN;   // RESUME
            default: state_nx = ST_RUN;
        endcase
    end

    // outputs of the controller
    always_comb begin
        halted = 1'b0;
        adv_en = 1'b0;
        unique case (state)
            ST_RUN:  adv_en = tick && !map_wr;
            ST_HALT: halted = 1'b1;
            default: halted = 1'b0;
        endcase
    end

    // one-second advance with calendar carries
    always_comb begin
        adv = cal;
        if (cal.sec != 6'd59) begin
            adv.sec = cal.sec + 6'd1;
        end else begin
            adv.sec = 6'd0;
            if (cal.min != 6'd59) begin
                adv.min = cal.min + 6'd1;
            end else begin
                adv.min = 6'd0;
                if (cal.hour != 5'd23) begin
                    adv.hour = cal.hour + 5'd1;
                end else begin
                    adv.hour = 5'd0;
                    adv.wday = (cal.wday >= 3'd6) ? 3'd0 : cal.wday + 3'd1;
                    if (cal.date < month_days(cal.mon0, cal.yr)) begin
                        adv.date = cal.date + 5'd1;
                    end else begin
                        adv.date = 5'd1;
                        if (cal.mon0 != 4'd11) begin
                            adv.mon0 = cal.mon0 + 4'd1;
                        end else begin
                            adv.mon0 = 4'd0;
                            adv.yr   = (cal.yr == 7'd99) ? 7'd0 : cal.yr + 7'd1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal <= '{sec: 6'd0, min: 6'd0, hour: 5'd0, wday: 3'd0,
                     date: 5'd1, mon0: 4'd0, yr: 7'd0};
        end else if (map_wr) begin
            if (hit.sec)  cal.sec  <= wbin[5:0];
            if (hit.min)  cal.min  <= wbin[5:0];
            if (hit.hour) cal.hour <= wbin[4:0];
            if (hit.wday) cal.wday <= wdata[2:0];
            if (hit.date) cal.date <= wbin[4:0];
            if (hit.mon)  cal.mon0 <= 4'(wbin - 7'd1);
            if (hit.yr)   cal.yr   <= wbin;
        end else if (adv_en) begin
            cal <= adv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 8'h90;
            wflag  <= 1'b0;
        end else begin
            if (hit.ctrl) ctrl_q <= (wdata & 8'h5F) | 8'h90;
            if (hit.wday) wflag  <= wdata[6];
        end
    end

endmodule

// File: rtl/bcdcal_rdport.sv
module bcdcal_rdport
    import bcdcal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  cal_t              cal,
    input  logic              halted,
    input  logic [7:0]        ctrl_q,
    input  logic              wflag,
    output logic [7:0]        rdata
);
    localparam int BASE = (1 << ADDR_W) - 8;

    reg_ofs_e   ofs;
    logic [7:0] rd_mux;
    logic [7:0] sec_bcd;

    assign ofs     = reg_ofs_e'(addr[2:0]);
    assign sec_bcd = bin_to_bcd({1'b0, cal.sec});

    always_comb begin
        rd_mux = 8'hFF;
        if (addr >= ADDR_W'(BASE)) begin
            unique case (ofs)
                OFS_CTRL: rd_mux = ctrl_q;
                OFS_SEC:  rd_mux = {halted, sec_bcd[6:0]};
                OFS_MIN:  rd_mux = bin_to_bcd({1'b0, cal.min});
                OFS_HOUR: rd_mux = bin_to_bcd({2'b0, cal.hour});
                OFS_WDAY: rd_mux = {1'b0, wflag, 3'b000, cal.wday};
                OFS_DATE: rd_mux = bin_to_bcd({2'b0, cal.date});
                OFS_MON:  rd_mux = bin_to_bcd(7'(cal.mon0) + 7'd1);
                OFS_YEAR: rd_mux = bin_to_bcd(cal.yr);
                default:  rd_mux = 8'hFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= 8'h00;
        else if (rd_en) rdata <= rd_mux;
    end

endmodule

// File: rtl/bcd_clock_regs.sv
module bcd_clock_regs
    import bcdcal_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int BASE_YEAR = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [7:0]        rdata,
    input  logic              tick_1hz,
    output logic [5:0]        cur_sec,
    output logic [5:0]        cur_min,
    output logic [4:0]        cur_hour,
    output logic [2:0]        cur_wday,
    output logic [4:0]        cur_date,
    output logic [3:0]        cur_month,
    output logic [15:0]       cur_year,
    output logic              halted
);
    wr_hit_t    hit;
    logic [6:0] wbin;
    logic       map_wr;
    cal_t       cal;
    logic [7:0] ctrl_q;
    logic       wflag;

    bcdcal_wrdecode #(.ADDR_W(ADDR_W)) wrdec_i (
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .hit   (hit),
        .wbin  (wbin),
        .map_wr(map_wr)
    );

    bcdcal_core core_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1hz),
        .hit   (hit),
        .wbin  (wbin),
        .wdata (wdata),
        .map_wr(map_wr),
        .cal   (cal),
        .halted(halted),
        .ctrl_q(ctrl_q),
        .wflag (wflag)
    );

    bcdcal_rdport #(.ADDR_W(ADDR_W)) rdport_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .addr  (addr),
        .cal   (cal),
        .halted(halted),
        .ctrl_q(ctrl_q),
        .wflag (wflag),
        .rdata (rdata)
    );

    assign cur_sec   = cal.sec;
    assign cur_min   = cal.min;
    assign cur_hour  = cal.hour;
    assign cur_wday  = cal.wday;
    assign cur_date  = cal.date;
    assign cur_month = cal.mon0 + 4'd1;
    assign cur_year  = 16'(BASE_YEAR) + {9'b0, cal.yr};

endmodule

// File: rtl/bcd_clock_regs_chk.sv
module bcd_clock_regs_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        rdata,
    input logic              tick_1hz,
    input logic [5:0]        cur_sec,
    input logic [5:0]        cur_min,
    input logic [4:0]        cur_hour,
    input logic [2:0]        cur_wday,
    input logic [4:0]        cur_date,
    input logic [3:0]        cur_month,
    input logic [15:0]       cur_year,
    input logic              halted
);
    localparam int BASE = (1 << ADDR_W) - 8;

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !wr_en) |=> ($stable(cur_sec) && $stable(cur_min) && $stable(cur_hour)
                               && $stable(cur_wday) && $stable(cur_date) && $stable(cur_month)
                               && $stable(cur_year))); // R3

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && tick_1hz && !wr_en) |=>
            (cur_sec == (($past(cur_sec) == 6'd59) ? 6'd0 : $past(cur_sec) + 6'd1))); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !wr_en) |=> ($stable(cur_sec) && $stable(cur_min) && $stable(cur_date))); // R9

    AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_sec <= 6'd59) && (cur_min <= 6'd59) && (cur_hour <= 5'd23)
        && (cur_date >= 5'd1) && (cur_month >= 4'd1) && (cur_month <= 4'd12)); // R10

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R12

    AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr < ADDR_W'(BASE))) |=> (rdata == 8'hFF)); // R11

    AST_CTRL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == ADDR_W'(BASE))) |=> (rdata[7] && rdata[4] && !rdata[5])); // R8

endmodule

bind bcd_clock_regs bcd_clock_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .tick_1hz (tick_1hz),
    .cur_sec  (cur_sec),
    .cur_min  (cur_min),
    .cur_hour (cur_hour),
    .cur_wday (cur_wday),
    .cur_date (cur_date),
    .cur_month(cur_month),
    .cur_year (cur_year),
    .halted   (halted)
);

// File: tb/bcd_clock_regs_tb_top.sv
module bcd_clock_regs_tb_top;
    localparam int AW   = 4;
    localparam int BASE = (1 << AW) - 8;
    localparam int BY   = 2000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = 8'h00;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic          tick_1hz = 1'b0;
    logic [7:0]    rdata;
    logic [5:0]    cur_sec;
    logic [5:0]    cur_min;
    logic [4:0]    cur_hour;
    logic [2:0]    cur_wday;
    logic [4:0]    cur_date;
    logic [3:0]    cur_month;
    logic [15:0]   cur_year;
    logic          halted;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    bcd_clock_regs #(.ADDR_W(AW), .BASE_YEAR(BY)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .tick_1hz(tick_1hz), .cur_sec(cur_sec),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
        .cur_date(cur_date), .cur_month(cur_month), .cur_year(cur_year),
        .halted(halted)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int to_bcd(input int b);
        return ((b / 10) << 4) | (b % 10);
    endfunction

    task automatic wr(input int ofs, input int v);
        @(negedge clk);
        addr = AW'(BASE + ofs); wdata = 8'(v); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int ofs, output int v);
        @(negedge clk);
        addr = AW'(BASE + ofs); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = int'(rdata);
    endtask

    task automatic pulse();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic set_time(input int s, input int m, input int h, input int wd,
                            input int d, input int mo, input int y);
        wr(7, y); wr(6, mo); wr(5, d); wr(4, wd); wr(3, h); wr(2, m); wr(1, s);
    endtask

    // all 256 bytes into one BCD field; model follows accepted values
    task automatic sweep(input int ofs, input int mask, input int lo, input int hi,
                         input string req, inout int model);
        int r;
        for (int v = 0; v < 256; v++) begin
            int fld = v & mask;
            int val = (fld >> 4) * 10 + (fld & 15);
            bit ok  = ((fld & 15) <= 9) && ((fld >> 4) <= 9) && val >= lo && val <= hi;
            if (ok) model = val;
            wr(ofs, v);
            rd(ofs, r);
            check(req, r, to_bcd(model) | ((ofs == 1) ? (v & 8'h80) : 0));
        end
    endtask

    initial begin
        int r, m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(0, r); check("R1 ctrl", r, 8'h90);
        rd(1, r); check("R1 sec", r, 0);
        rd(2, r); check("R1 min", r, 0);
        rd(3, r); check("R1 hour", r, 0);
        rd(4, r); check("R1 wday", r, 0);
        rd(5, r); check("R1 date", r, 1);
        rd(6, r); check("R1 month", r, 1);
        rd(7, r); check("R1 year", r, 0);
        check("R1 halted", int'(halted), 0);
        check("R1 cur_year", int'(cur_year), BY);

        // R8 control
        for (int v = 0; v < 256; v++) begin
            wr(0, v); rd(0, r);
            check("R8 ctrl", r, (v & 8'h5F) | 8'h90);
        end
        // R7 weekday and flag
        for (int v = 0; v < 256; v++) begin
            wr(4, v); rd(4, r);
            check("R7 wday", r, (v & 8'h40) | (v & 7));
        end

        m = 0; sweep(1, 8'h7F, 0, 59, "R2 sec", m);
        wr(1, 8'h00);
        check("R3 cleared", int'(halted), 0);
        m = 0; sweep(2, 8'h7F, 0, 59, "R4 min", m);
        m = 0; sweep(3, 8'h3F, 0, 23, "R4 hour", m);
        m = 1; sweep(5, 8'h3F, 1, 31, "R5 date", m);
        m = 1; sweep(6, 8'h1F, 1, 12, "R5 month", m);
        m = 0; sweep(7, 8'hFF, 0, 99, "R6 year", m);
        wr(7, 8'h24);
        check("R6 cur_year", int'(cur_year), BY + 24);

        // R9 run of 3661 pulses from 10:00:00
        set_time(8'h00, 8'h00, 8'h10, 2, 8'h15, 8'h06, 8'h21);
        for (int n = 1; n <= 3661; n++) begin
            pulse();
            check("R9 sec", int'(cur_sec), n % 60);
            check("R9 min", int'(cur_min), (n / 60) % 60);
            check("R9 hour", int'(cur_hour), 10 + n / 3600);
        end
        rd(3, r); check("R9 hour bcd", r, 8'h11);

        // R10 month ends
        set_time(8'h59, 8'h59, 8'h23, 3, 8'h28, 8'h02, 8'h04); pulse();
        check("R10 leap date", int'(cur_date), 29); check("R10 leap mon", int'(cur_month), 2);
        check("R10 wday", int'(cur_wday), 4);
        set_time(8'h59, 8'h59, 8'h23, 3, 8'h29, 8'h02, 8'h04); pulse();
        check("R10 leap end date", int'(cur_date), 1); check("R10 leap end mon", int'(cur_month), 3);
        set_time(8'h59, 8'h59, 8'h23, 3, 8'h28, 8'h02, 8'h05); pulse();
        check("R10 common date", int'(cur_date), 1); check("R10 common mon", int'(cur_month), 3);
        set_time(8'h59, 8'h59, 8'h23, 3, 8'h30, 8'h04, 8'h05); pulse();
        check("R10 apr date", int'(cur_date), 1); check("R10 apr mon", int'(cur_month), 5);
        set_time(8'h59, 8'h59, 8'h23, 3, 8'h30, 8'h01, 8'h05); pulse();
        check("R10 jan30 date", int'(cur_date), 31);
        set_time(8'h59, 8'h59, 8'h23, 6, 8'h31, 8'h12, 8'h99); pulse();
        check("R10 year wrap", int'(cur_year), BY); check("R10 jan", int'(cur_month), 1);
        check("R10 day1", int'(cur_date), 1); check("R10 wday wrap", int'(cur_wday), 0);
        check("R10 hour", int'(cur_hour), 0);
        set_time(8'h59, 8'h59, 8'h23, 7, 8'h10, 8'h03, 8'h05); pulse();
        check("R10 wday7", int'(cur_wday), 0);

        // R3 stop, then resume via an invalid seconds write
        wr(1, 8'h85);
        check("R3 halted", int'(halted), 1);
        repeat (3) pulse();
        check("R3 frozen", int'(cur_sec), 5);
        rd(1, r); check("R3 read stop", r, 8'h85);
        wr(1, 8'h7F);
        check("R3 resumed", int'(halted), 0);
        check("R3 held", int'(cur_sec), 5);
        pulse();
        check("R3 counts", int'(cur_sec), 6);

        // R13 pulse coinciding with mapped and unmapped writes
        @(negedge clk);
        addr = AW'(BASE + 2); wdata = 8'h10; wr_en = 1'b1; tick_1hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
        check("R13 dropped", int'(cur_sec), 6);
        check("R13 min written", int'(cur_min), 10);
        @(negedge clk);
        addr = AW'(1); wdata = 8'h33; wr_en = 1'b1; tick_1hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
        check("R13 unmapped keeps pulse", int'(cur_sec), 7);

        // R11 unmapped reads and an aliasing write
        for (int a = 0; a < BASE; a++) begin
            @(negedge clk); addr = AW'(a); rd_en = 1'b1;
            @(negedge clk); rd_en = 1'b0;
            check("R11 unmapped read", int'(rdata), 8'hFF);
        end
        rd(1, r); check("R11 sec untouched", r, 8'h07);

        // R12 read data holds without rd_en
        rd(0, r);
        @(negedge clk); addr = AW'(BASE + 7);
        repeat (3) @(negedge clk);
        check("R12 hold", int'(rdata), r);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule